// File: doc/BRIEF.md
# Monochrome Framebuffer Write Unpacker

This block takes a rectangular write of a one-bit-per-pixel image and turns it into eight-bit brightness values in a small frame store that it holds itself. A write starts with a one-cycle `wr_start` pulse. The pulse carries the rectangle origin, width, height and pitch. The packed image bytes then arrive on a valid/ready byte stream. Each set bit becomes the current brightness, and each clear bit becomes 0. Every store update also appears on the `fs_we`/`fs_addr`/`fs_data` strobe outputs, so a scan-out engine elsewhere can keep its own copy in step.

A brightness request walks the whole frame store once. Each lit pixel is moved by the difference between the new and the old brightness, and the result is clamped to 1..255. Unlit pixels stay dark. Writes that fall outside the display, or whose pitch is shorter than their width, are refused with a one-cycle error pulse.

The controller is a five-state machine:
- `ST_IDLE` waits for work.
- `ST_UNPACK` fetches bytes and spends one bit per cycle.
- `ST_RESCALE` walks the store after a brightness change.
- `ST_DONE` marks a completed write.
- `ST_REJECT` marks a refused one.

The transitions are:
- `ST_IDLE` goes to `ST_REJECT` on a bad start, to `ST_DONE` on an empty rectangle, to `ST_UNPACK` on a good start, and to `ST_RESCALE` on a brightness request with no start.
- `ST_UNPACK` goes to `ST_DONE` when the last pixel bit is spent.
- `ST_RESCALE` goes to `ST_IDLE` after the last address.
- `ST_DONE` and `ST_REJECT` return to `ST_IDLE` after one cycle.

Top module: `mono_fb_unpacker`

## Requirements
- R1: A start with x >= display width, y >= display height, x + width > display width, or y + height > display height raises `wr_err` for exactly one cycle. It writes no pixel and accepts no byte.
- R2: A start whose pitch is smaller than its width is refused in the same way as R1.
- R3: Pixel bits are taken from each byte starting at bit 0 and ending at bit 7. The next byte is requested only after bit 7 has been used.
- R4: After the width pixels of each row, pitch − width bits are discarded, and the bit position carries across byte boundaries. The write ends at the last pixel of the last row, so exactly ceil(((height − 1) × pitch + width) / 8) bytes are accepted.
- R5: A set bit stores the current brightness at address x + y × display width, and a clear bit stores 0. Addresses outside the rectangle are untouched.
- R6: An accepted write ends with a single-cycle `wr_done` pulse. A write with zero width or zero height is accepted, pulses `wr_done`, takes no byte and writes nothing.
- R7: A requested brightness of 0 becomes 1, and any other value is used as given. Brightness is 255 after reset.
- R8: On a brightness request, every nonzero stored pixel becomes clamp(old pixel + new − old brightness, 1, 255). Pixels that are 0 stay 0 and produce no write strobe.
- R9: `busy` is high in every state except `ST_IDLE`. While busy, `wr_start` and `bri_req` are ignored, and `in_ready` stays low outside `ST_UNPACK`. When `wr_start` and `bri_req` arrive together in `ST_IDLE`, the write is taken and the brightness request is dropped.
- R10: After reset, the store holds all zeros, `busy`, `in_ready`, `wr_done`, `wr_err` and `fs_we` are low, and the block sits in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | One-cycle request to begin a rectangle write |
| wr_x | input | CW | Rectangle left column |
| wr_y | input | CW | Rectangle top row |
| wr_w | input | CW | Rectangle width in pixels |
| wr_h | input | CW | Rectangle height in pixels |
| wr_pitch | input | CW | Bits per source row, padding included |
| in_valid | input | 1 | Packed byte available |
| in_data | input | 8 | Packed pixel byte, first pixel in bit 0 |
| in_ready | output | 1 | Block can take a byte |
| bri_req | input | 1 | One-cycle brightness change request |
| bri_val | input | 8 | Requested brightness |
| busy | output | 1 | A write or rescale is in progress |
| wr_done | output | 1 | One-cycle end-of-write pulse |
| wr_err | output | 1 | One-cycle write-refused pulse |
| fs_we | output | 1 | Frame store write strobe |
| fs_addr | output | AW | Frame store write address |
| fs_data | output | 8 | Frame store write data |

## Verification
The unpacker is exercised with the following rectangles:
- A full-screen write whose pitch equals its width, which shows that the bit position carries across byte boundaries.
- Narrow rectangles with wide padding, and a single row with a pitch larger than the display, which separate correct padding skips from off-by-one skips.
- A single corner pixel.
- An empty rectangle.

The image bytes come from a seeded pattern, so a reversed bit order, a wrong row stride or a miscounted byte total each show up as a frame mismatch or a wrong byte count. Refused writes cover each bound on its own and the pitch rule, so each comparison can be told apart. The brightness patterns are:
- A drop.
- A request of 0, which shows the clamp.
- A rise back to full.
- Requests raised while busy, which must leave both the frame and the brightness used by later writes unchanged.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

    localparam int PIX_W   = 8;
    localparam int BRI_TOP = 255;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNPACK,
        ST_RESCALE,
        ST_DONE,
        ST_REJECT
    } mfb_state_e;

    // Requested brightness: 0 is lifted to 1, otherwise unchanged.
    function automatic logic [PIX_W-1:0] bri_limit(input logic [PIX_W-1:0] v);
        return (v == '0) ? PIX_W'(1) : v;
    endfunction

    // Shift a stored pixel by a signed delta, clamped to 1..255.
    function automatic logic [PIX_W-1:0] pix_shift(input logic [PIX_W-1:0] v,
                                                    input logic signed [PIX_W:0] d);
        logic signed [PIX_W+2:0] s;
        s = $signed({3'b000, v}) + d;
        if (s < 1)
            return PIX_W'(1);
        else if (s > BRI_TOP)
            return PIX_W'(BRI_TOP);
        else
            return s[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/mfb_bounds.sv
module mfb_bounds #(
    parameter int DISP_W = 5,
    parameter int DISP_H = 5,
    parameter int CW     = 8
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [CW-1:0] w,
    input  logic [CW-1:0] h,
    input  logic [CW-1:0] pitch,
    output logic          reject,
    output logic          empty
);
    localparam logic [CW:0] LIM_W = (CW+1)'(DISP_W);
    localparam logic [CW:0] LIM_H = (CW+1)'(DISP_H);

    logic [CW:0] x_end;
    logic [CW:0] y_end;

    always_comb begin
        x_end  = {1'b0, x} + {1'b0, w};
        y_end  = {1'b0, y} + {1'b0, h};
        reject = ({1'b0, x} >= LIM_W) || ({1'b0, y} >= LIM_H) ||
                 (x_end > LIM_W) || (y_end > LIM_H) || (pitch < w);
        empty  = (w == '0) || (h == '0);
    end

endmodule

// File: rtl/mfb_bitsrc.sv
module mfb_bitsrc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       take,
    output logic       have,
    output logic       cur_bit
);
    logic [7:0] byte_q;
    logic [2:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            idx_q  <= '0;
            have   <= 1'b0;
        end else if (flush) begin
            have  <= 1'b0;
            idx_q <= '0;
        end else if (load) begin
            byte_q <= din;
            idx_q  <= '0;
            have   <= 1'b1;
        end else if (take && have) begin
            idx_q <= idx_q + 3'd1;
            if (idx_q == 3'd7)
                have <= 1'b0;
        end
    end

    assign cur_bit = byte_q[idx_q];

    // R3: a new byte only lands once the previous one is spent
    a_r3_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !have);

    // R3: the first bit used from a fresh byte is bit 0
    a_r3_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flush) |=> (have && idx_q == 3'd0));

endmodule

// File: rtl/mfb_store.sv
module mfb_store #(
    parameter int DEPTH = 25,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'd0;

    // R5: every write lands inside the display
    a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/mono_fb_unpacker.sv
module mono_fb_unpacker #(
    parameter int DISP_W = 5,
    parameter int DISP_H = 5,
    parameter int CW     = 8,
    localparam int DEPTH = DISP_W * DISP_H,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start,
    input  logic [CW-1:0] wr_x,
    input  logic [CW-1:0] wr_y,
    input  logic [CW-1:0] wr_w,
    input  logic [CW-1:0] wr_h,
    input  logic [CW-1:0] wr_pitch,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    input  logic          bri_req,
    input  logic [7:0]    bri_val,
    output logic          busy,
    output logic          wr_done,
    output logic          wr_err,
    output logic          fs_we,
    output logic [AW-1:0] fs_addr,
    output logic [7:0]    fs_data
);
    import mfb_pkg::*;

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [AW-1:0] ROW_STEP  = AW'(DISP_W);

    mfb_state_e state, next_state;

    logic [CW-1:0]      w_q, h_q, p_q, col_q, row_q;
    logic [AW-1:0]      base_q, scan_q;
    logic [7:0]         cur_bri;
    logic signed [8:0]  delta_q;

    logic               bad, empty;
    logic               have, cur_bit, take, load, flush;
    logic               last_pix, row_end, in_rect;
    logic [7:0]         bri_new;
    logic signed [8:0]  delta_new;
    logic [AW-1:0]      start_base;
    logic [7:0]         rd_data;

    mfb_bounds #(.DISP_W(DISP_W), .DISP_H(DISP_H), .CW(CW)) u_bounds (
        .x(wr_x), .y(wr_y), .w(wr_w), .h(wr_h), .pitch(wr_pitch),
        .reject(bad), .empty(empty)
    );

    mfb_bitsrc u_bitsrc (
        .clk(clk), .rst_n(rst_n), .flush(flush), .load(load),
        .din(in_data), .take(take), .have(have), .cur_bit(cur_bit)
    );

    mfb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(fs_we), .waddr(fs_addr),
        .wdata(fs_data), .raddr(scan_q), .rdata(rd_data)
    );

    // Walk decode
    always_comb begin
        in_ready   = (state == ST_UNPACK) && !have;
        load       = in_valid && in_ready;
        take       = (state == ST_UNPACK) && have;
        flush      = (state == ST_IDLE);
        in_rect    = (col_q < w_q);
        row_end    = (col_q == p_q - CW'(1));
        last_pix   = (row_q == h_q - CW'(1)) && (col_q == w_q - CW'(1));
        bri_new    = bri_limit(bri_val);
        delta_new  = $signed({1'b0, bri_new}) - $signed({1'b0, cur_bri});
        start_base = AW'(int'(wr_y) * DISP_W + int'(wr_x));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= next_state;
    end

    // Transitions
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_start) begin
                    if (bad)
                        next_state = ST_REJECT;
                    else if (empty)
                        next_state = ST_DONE;
                    else
                        next_state = ST_UNPACK;
                end else if (bri_req) begin
                    next_state = ST_RESCALE;
                end
            end
            ST_UNPACK:  if (take && last_pix) next_state = ST_DONE;
            ST_RESCALE: if (scan_q == LAST_ADDR) next_state = ST_IDLE;
            ST_DONE:    next_state = ST_IDLE;
            ST_REJECT:  next_state = ST_IDLE;
            default:    next_state = ST_IDLE;
        endcase
    end

    // Walk counters and brightness
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q     <= '0;
            h_q     <= '0;
            p_q     <= '0;
            col_q   <= '0;
            row_q   <= '0;
            base_q  <= '0;
            scan_q  <= '0;
            cur_bri <= 8'(BRI_TOP);
            delta_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (wr_start) begin
                        if (!bad) begin
                            w_q    <= wr_w;
                            h_q    <= wr_h;
                            p_q    <= wr_pitch;
                            col_q  <= '0;
                            row_q  <= '0;
                            base_q <= start_base;
                        end
                    end else if (bri_req) begin
                        cur_bri <= bri_new;
                        delta_q <= delta_new;
                        scan_q  <= '0;
                    end
                end
                ST_UNPACK: begin
                    if (take && !last_pix) begin
                        if (row_end) begin
                            col_q  <= '0;
                            row_q  <= row_q + CW'(1);
                            base_q <= base_q + ROW_STEP;
                        end else begin
                            col_q <= col_q + CW'(1);
                        end
                    end
                end
                ST_RESCALE: scan_q <= scan_q + AW'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        fs_we   = 1'b0;
        fs_addr = base_q + AW'(col_q);
        fs_data = '0;
        busy    = (state != ST_IDLE);
        wr_done = (state == ST_DONE);
        wr_err  = (state == ST_REJECT);
        unique case (state)
            ST_UNPACK: begin
                fs_we   = take && in_rect;
                fs_addr = base_q + AW'(col_q);
                fs_data = cur_bit ? cur_bri : 8'd0;
            end
            ST_RESCALE: begin
                fs_we   = (rd_data != 8'd0);
                fs_addr = scan_q;
                fs_data = pix_shift(rd_data, delta_q);
            end
            default: ;
        endcase
    end

    // R1: a refused start yields an error pulse and no store write
    a_r1_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_start && bad) |=> (wr_err && !fs_we && !in_ready));

    // R6: done lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    // R5: unpacked pixels are either dark or at the current brightness
    a_r5_pixel_value: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNPACK && fs_we) |-> (fs_data == 8'd0 || fs_data == cur_bri));

    // R7: brightness never reaches zero
    a_r7_bri_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cur_bri != 8'd0);

    // R8: rescaled pixels stay lit
    a_r8_rescale_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESCALE && fs_we) |-> (fs_data != 8'd0));

    // R9: no byte accepted outside unpacking
    a_r9_no_bytes_idle_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_UNPACK) |-> !in_ready);

    // R9: brightness held while busy
    a_r9_bri_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cur_bri));

endmodule

// File: tb/mono_fb_unpacker_test.sv
`timescale 1ns/1ps
module mono_fb_unpacker_test;

    localparam int W = 5;
    localparam int H = 5;
    localparam int D = W * H;
    localparam int AW = $clog2(D);

    typedef struct packed {
        logic [7:0] x, y, w, h, p, seed;
        logic       bad;
        logic       pbad;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 8'd0, 8'd5, 8'd5, 8'd5,  8'd1,  1'b0, 1'b0},
        '{8'd1, 8'd1, 8'd3, 8'd2, 8'd7,  8'd2,  1'b0, 1'b0},
        '{8'd2, 8'd0, 8'd3, 8'd5, 8'd3,  8'd3,  1'b0, 1'b0},
        '{8'd4, 8'd4, 8'd1, 8'd1, 8'd1,  8'd4,  1'b0, 1'b0},
        '{8'd0, 8'd2, 8'd5, 8'd1, 8'd12, 8'd5,  1'b0, 1'b0},
        '{8'd5, 8'd0, 8'd0, 8'd1, 8'd0,  8'd6,  1'b1, 1'b0},
        '{8'd2, 8'd0, 8'd4, 8'd1, 8'd4,  8'd7,  1'b1, 1'b0},
        '{8'd0, 8'd3, 8'd1, 8'd3, 8'd1,  8'd8,  1'b1, 1'b0},
        '{8'd0, 8'd0, 8'd3, 8'd1, 8'd2,  8'd9,  1'b1, 1'b1},
        '{8'd0, 8'd5, 8'd1, 8'd0, 8'd1,  8'd10, 1'b1, 1'b0},
        '{8'd1, 8'd1, 8'd0, 8'd3, 8'd0,  8'd11, 1'b0, 1'b0}
    };

    logic clk = 0, rst_n = 0;
    logic wr_start = 0, in_valid = 0, bri_req = 0;
    logic [7:0] wr_x = 0, wr_y = 0, wr_w = 0, wr_h = 0, wr_pitch = 0;
    logic [7:0] in_data = 0, bri_val = 0;
    logic in_ready, busy, wr_done, wr_err, fs_we;
    logic [AW-1:0] fs_addr;
    logic [7:0] fs_data;

    int checks = 0, errors = 0, cycles = 0, wcount = 0;
    int obs [D];
    int expf [D];
    int exp_bri = 255;

    always #10 clk = ~clk;

    mono_fb_unpacker #(.DISP_W(W), .DISP_H(H), .CW(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_x(wr_x), .wr_y(wr_y),
        .wr_w(wr_w), .wr_h(wr_h), .wr_pitch(wr_pitch), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .bri_req(bri_req), .bri_val(bri_val),
        .busy(busy), .wr_done(wr_done), .wr_err(wr_err), .fs_we(fs_we),
        .fs_addr(fs_addr), .fs_data(fs_data)
    );

    always @(negedge clk) begin
        if (rst_n && fs_we) begin
            obs[int'(fs_addr)] = int'(fs_data);
            wcount++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] gen_byte(input int seed, input int i);
        return 8'((seed * 29 + i * 113) ^ 8'h5A);
    endfunction

    task automatic check_frame(input string req);
        int bad = 0, first = 0;
        for (int a = 0; a < D; a++)
            if (obs[a] != expf[a]) begin
                if (bad == 0) first = a;
                bad++;
            end
        chk(bad == 0, req, obs[first], expf[first]);
    endtask

    task automatic model_write(input vec_t v);
        for (int r = 0; r < int'(v.h); r++)
            for (int c = 0; c < int'(v.w); c++) begin
                int k = r * int'(v.p) + c;
                logic [7:0] b = gen_byte(int'(v.seed), k / 8);
                expf[(int'(v.y) + r) * W + int'(v.x) + c] = b[k % 8] ? exp_bri : 0;
            end
    endtask

    function automatic int exp_bytes(input vec_t v);
        if (v.w == 0 || v.h == 0) return 0;
        return ((int'(v.h) - 1) * int'(v.p) + int'(v.w) + 7) / 8;
    endfunction

    task automatic run_write(input vec_t v, input bit with_bri,
                             output bit got_err, output bit got_done, output int nb);
        got_err = 0; got_done = 0; nb = 0;
        @(posedge clk); #1;
        wr_start = 1; wr_x = v.x; wr_y = v.y; wr_w = v.w; wr_h = v.h; wr_pitch = v.p;
        bri_req = with_bri; bri_val = 8'd7;
        for (int cyc = 0; cyc < 400; cyc++) begin
            @(negedge clk);
            if (in_valid && in_ready) nb++;
            if (wr_err) got_err = 1;
            if (wr_done) got_done = 1;
            if (got_err || got_done) break;
            @(posedge clk); #1;
            wr_start = 0; bri_req = 0;
            in_valid = 1; in_data = gen_byte(int'(v.seed), nb);
        end
        @(posedge clk); #1;
        wr_start = 0; bri_req = 0; in_valid = 0;
    endtask

    task automatic set_bri(input int v);
        int nb = (v == 0) ? 1 : v;
        int d = nb - exp_bri;
        @(posedge clk); #1; bri_req = 1; bri_val = 8'(v);
        @(posedge clk); #1; bri_req = 0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            @(negedge clk);
            if (!busy) break;
        end
        for (int a = 0; a < D; a++)
            if (expf[a] != 0) begin
                int s = expf[a] + d;
                expf[a] = (s < 1) ? 1 : (s > 255) ? 255 : s;
            end
        exp_bri = nb;
    endtask

    initial begin
        bit e, dn;
        int nb;
        for (int a = 0; a < D; a++) begin obs[a] = 0; expf[a] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R10: idle outputs after reset
        chk(!busy && !in_ready && !wr_done && !wr_err && !fs_we, "R10",
            {busy, in_ready, wr_done, wr_err, fs_we}, 0);

        // R10: store empty after reset -> a rescale produces no strobe; R7 zero request -> 1
        set_bri(0);
        chk(wcount == 0, "R10", wcount, 0);
        set_bri(255);
        chk(wcount == 0, "R10", wcount, 0);

        // Vector table: R7 default 255 used by the first writes
        for (int i = 0; i < NV; i++) begin
            run_write(VECS[i], 1'b0, e, dn, nb);
            if (VECS[i].bad) begin
                chk(e == 1 && dn == 0, VECS[i].pbad ? "R2" : "R1", e, 1);
                chk(nb == 0, "R1", nb, 0);
                check_frame("R1");
            end else begin
                chk(dn == 1 && e == 0, "R6", dn, 1);
                chk(nb == exp_bytes(VECS[i]), "R4", nb, exp_bytes(VECS[i]));
                model_write(VECS[i]);
                check_frame("R3 R5");
            end
        end

        // R8 lower and R7 clamp of zero request
        set_bri(100);
        check_frame("R8");
        set_bri(0);
        check_frame("R7");
        run_write(VECS[1], 1'b0, e, dn, nb);
        model_write(VECS[1]);
        check_frame("R7");
        set_bri(255);
        check_frame("R8");

        // R9: simultaneous start and brightness: write wins, brightness dropped
        run_write(VECS[2], 1'b1, e, dn, nb);
        chk(dn == 1, "R9", dn, 1);
        model_write(VECS[2]);
        check_frame("R9");

        // R9: start during rescale is ignored
        begin
            int seen = 0;
            @(posedge clk); #1; bri_req = 1; bri_val = 8'd40;
            @(posedge clk); #1; bri_req = 0;
            wr_start = 1; wr_x = 0; wr_y = 0; wr_w = 2; wr_h = 1; wr_pitch = 2;
            in_valid = 1; in_data = 8'hFF;
            @(posedge clk); #1; wr_start = 0;
            for (int cyc = 0; cyc < 200; cyc++) begin
                @(negedge clk);
                if (wr_done || wr_err || in_ready) seen++;
                if (!busy) break;
            end
            @(posedge clk); #1; in_valid = 0;
            repeat (3) begin
                @(negedge clk);
                if (wr_done || wr_err || busy) seen++;
            end
            chk(seen == 0, "R9", seen, 0);
            for (int a = 0; a < D; a++)
                if (expf[a] != 0) expf[a] = (expf[a] - 215 < 1) ? 1 : expf[a] - 215;
            exp_bri = 40;
            check_frame("R8");
        end

        // R5: later write uses the new brightness
        run_write(VECS[0], 1'b0, e, dn, nb);
        model_write(VECS[0]);
        check_frame("R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule